// File: doc/BRIEF.md
# CPU Exception Entry Unit

This block performs the system-control register update that a MIPS-style processor makes when it takes an exception. The pipeline presents an exception request together with a 5-bit exception code, the current fetch PC, the instruction word, a branch-delay flag and the present contents of the Cause, SR and EPC registers. On the clock edge that ends the request cycle, the block produces the new Cause, SR and EPC values. In the next cycle it raises a one-cycle redirect pulse carrying the exception vector.

Two kinds of fault are handled. An instruction-caused fault, such as a reserved instruction (code 10), locates the faulting instruction one step behind the fetch PC and records the coprocessor number held in the instruction word. A breakpoint (code 9) uses the fetch PC itself as the faulting address, records no coprocessor number and vectors to a separate debug entry. Interrupt arbitration, address-translation faults and instruction decode are left to other blocks.

Top module: `exc_entry_unit`

## Requirements
- R1: After a request, Cause bits 6:2 hold the request's 5-bit exception code. The reserved-instruction code is 10 and the breakpoint code is 9.
- R2: After a request, Cause bits 9:8 equal the incoming Cause bits 9:8. Every Cause bit not assigned by R1, R3 or R4 reads 0.
- R3: For any code other than 9, Cause bits 29:28 hold instruction bits 27:26. For code 9 they read 0.
- R4: After a request, Cause bit 31 equals the branch-delay flag that came with the request.
- R5: After a request, SR bits 5:0 equal the incoming SR bits 3:0 shifted left by 2, with bits 1:0 cleared. SR bits 31:6 are passed through unchanged.
- R6: The faulting address is the fetch PC minus 4 for any code other than 9, and the fetch PC itself for code 9. EPC is the faulting address minus 4 when the branch-delay flag is set, and the faulting address otherwise. The arithmetic is modulo 2^32.
- R7: The redirect PC is 0x80000040 for code 9 and 0x80000080 for every other code.
- R8: The Cause, SR and EPC outputs and the redirect pulse change in the cycle after the request. The redirect pulse is high for exactly one cycle for each request cycle, so back-to-back requests give back-to-back pulses.
- R9: In a cycle without a request, the Cause, SR, EPC and redirect PC outputs keep their values, whatever the other inputs do.
- R10: During and right after reset, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, one cycle per exception |
| exc_code | input | 5 | Exception code |
| fetch_pc | input | 32 | Current fetch PC |
| insn_word | input | 32 | Current instruction word |
| in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| cause_cur | input | 32 | Present Cause register |
| sr_cur | input | 32 | Present status register |
| epc_cur | input | 32 | Present EPC register, replaced on entry |
| cause_new | output | 32 | Updated Cause register |
| sr_new | output | 32 | Updated status register |
| epc_new | output | 32 | Updated EPC register |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Exception vector address |

## Verification
The result registers are written only on a request edge, so a wrong field shows up in the first cycle after that request. It stays visible on cause_new, sr_new or epc_new until the next request. A wrong choice of fault kind would move EPC by 4, clear or set Cause bits 29:28 and flip the vector all together, so the bench pairs both kinds with both delay states. Stale or spurious updates are caught by checking the hold behaviour after changing inputs with no request, and by checking the pulse in the cycle after each request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int CAUSE_CODE_LSB = 2;
   localparam int CAUSE_SW_LSB   = 8;
   localparam int CAUSE_CE_LSB   = 28;
   localparam int INSN_CE_LSB    = 26;
   localparam int SR_PAIR_W      = 2;

   typedef enum logic {
      FK_INSN  = 1'b0,
      FK_BREAK = 1'b1
   } fault_kind_e;
endpackage

// File: rtl/exc_fault_addr.sv
module exc_fault_addr
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int INSN_STEP = 4
) (
   input  fault_kind_e       kind,
   input  logic [XLEN-1:0]   fetch_pc,
   input  logic              in_delay,
   output logic [XLEN-1:0]   epc_next
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_STEP);

   logic [XLEN-1:0] fault_pc;

   generate
      if (INSN_STEP <= 0) begin : g_bad_step
         $error("exc_fault_addr: INSN_STEP must be positive");
      end
   endgenerate

   always_comb begin
      fault_pc = (kind == FK_BREAK) ? fetch_pc : (fetch_pc - STEP);
      epc_next = in_delay ? (fault_pc - STEP) : fault_pc;
   end
endmodule

// File: rtl/exc_cause_build.sv
module exc_cause_build
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CODE_W    = 5,
   parameter bit COP_FIELD = 1'b1
) (
   input  fault_kind_e       kind,
   input  logic [CODE_W-1:0] code,
   input  logic [1:0]        insn_ce,
   input  logic              in_delay,
   input  logic [XLEN-1:0]   cause_in,
   output logic [XLEN-1:0]   cause_next
);
   localparam int BD_BIT = XLEN - 1;

   logic [XLEN-1:0] kept;
   logic [XLEN-1:0] ce_part;
   logic [XLEN-1:0] code_part;

   generate
      if (CAUSE_CODE_LSB + CODE_W > CAUSE_SW_LSB) begin : g_bad_code
         $error("exc_cause_build: code field overlaps software bits");
      end
      if (COP_FIELD) begin : g_cop
         always_comb begin
            ce_part = '0;
            if (kind == FK_INSN)
               ce_part[CAUSE_CE_LSB +: 2] = insn_ce;
         end
      end else begin : g_nocop
         always_comb ce_part = '0;
      end
   endgenerate

   always_comb begin
      kept = '0;
      kept[CAUSE_SW_LSB +: 2] = cause_in[CAUSE_SW_LSB +: 2];
      code_part = '0;
      code_part[CAUSE_CODE_LSB +: CODE_W] = code;
      cause_next = kept | ce_part | code_part;
      cause_next[BD_BIT] = in_delay;
   end
endmodule

// File: rtl/exc_sr_push.sv
module exc_sr_push
   import exc_entry_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int PAIRS = 3
) (
   input  logic [XLEN-1:0] sr_in,
   output logic [XLEN-1:0] sr_next
);
   localparam int STACK_W = PAIRS * SR_PAIR_W;

   generate
      if (PAIRS < 2 || STACK_W > XLEN) begin : g_bad_pairs
         $error("exc_sr_push: PAIRS out of range");
      end
      if (STACK_W < XLEN) begin : g_upper
         assign sr_next[XLEN-1:STACK_W] = sr_in[XLEN-1:STACK_W];
      end
      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
         if (i == 0) begin : g_cur
            assign sr_next[SR_PAIR_W-1:0] = '0;
         end else begin : g_shift
            assign sr_next[i*SR_PAIR_W +: SR_PAIR_W] = sr_in[(i-1)*SR_PAIR_W +: SR_PAIR_W];
         end
      end
   endgenerate
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              CODE_W     = 5,
   parameter int              INSN_STEP  = 4,
   parameter int              SR_PAIRS   = 3,
   parameter bit              COP_FIELD  = 1'b1,
   parameter logic [4:0]      CODE_BREAK = 5'd9,
   parameter logic [4:0]      CODE_RSVD  = 5'd10,
   parameter logic [31:0]     VEC_BREAK  = 32'h8000_0040,
   parameter logic [31:0]     VEC_GEN    = 32'h8000_0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [4:0]        exc_code,
   input  logic [31:0]       fetch_pc,
   input  logic [31:0]       insn_word,
   input  logic              in_delay,
   input  logic [31:0]       cause_cur,
   input  logic [31:0]       sr_cur,
   input  logic [31:0]       epc_cur,
   output logic [31:0]       cause_new,
   output logic [31:0]       sr_new,
   output logic [31:0]       epc_new,
   output logic              redir_valid,
   output logic [31:0]       redir_pc
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("exc_entry_unit: port widths are fixed at 32 bits");
      end
      if (CODE_W != 5) begin : g_bad_codew
         $error("exc_entry_unit: exception code must be 5 bits");
      end
      if (CODE_BREAK == CODE_RSVD) begin : g_bad_codes
         $error("exc_entry_unit: cause codes must differ");
      end
   endgenerate

   fault_kind_e       kind;
   logic [XLEN-1:0]   cause_d, sr_d, epc_d, vec_d;
   logic              unused_epc;

   assign kind       = (exc_code == CODE_BREAK) ? FK_BREAK : FK_INSN;
   assign vec_d      = (kind == FK_BREAK) ? VEC_BREAK : VEC_GEN;
   assign unused_epc = ^{epc_cur, insn_word[31:28], insn_word[25:0], CODE_RSVD};

   exc_cause_build #(
      .XLEN(XLEN), .CODE_W(CODE_W), .COP_FIELD(COP_FIELD)
   ) u_cause (
      .kind(kind), .code(exc_code), .insn_ce(insn_word[INSN_CE_LSB +: 2]),
      .in_delay(in_delay), .cause_in(cause_cur), .cause_next(cause_d)
   );

   exc_sr_push #(.XLEN(XLEN), .PAIRS(SR_PAIRS)) u_sr (
      .sr_in(sr_cur), .sr_next(sr_d)
   );

   exc_fault_addr #(.XLEN(XLEN), .INSN_STEP(INSN_STEP)) u_epc (
      .kind(kind), .fetch_pc(fetch_pc), .in_delay(in_delay), .epc_next(epc_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_new   <= '0;
         sr_new      <= '0;
         epc_new     <= '0;
         redir_pc    <= '0;
         redir_valid <= 1'b0;
      end else begin
         redir_valid <= exc_req;
         if (exc_req) begin
            cause_new <= cause_d;
            sr_new    <= sr_d;
            epc_new   <= epc_d;
            redir_pc  <= vec_d;
         end
      end
   end

   // R8: one pulse per request cycle
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> redir_valid);
   p_nopulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> !redir_valid);
   // R2: software-interrupt bits carried across
   p_swint_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> cause_new[9:8] == $past(cause_cur[9:8]));
   // R4: delay flag recorded
   p_bd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> cause_new[31] == $past(in_delay));
   // R5: mode stack pushed
   p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (sr_new[5:0] == {$past(sr_cur[3:0]), 2'b00}) &&
                  (sr_new[31:6] == $past(sr_cur[31:6])));
   // R1: code lands in the code field
   p_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> cause_new[6:2] == $past(exc_code));
   // R9: nothing moves without a request
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> $stable(cause_new) && $stable(sr_new) &&
                   $stable(epc_new) && $stable(redir_pc));
   // R7: only the two vectors ever appear
   p_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_pc == VEC_BREAK) || (redir_pc == VEC_GEN));
endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [31:0] fetch_pc = '0, insn_word = '0, cause_cur = '0, sr_cur = '0, epc_cur = '0;
   logic        in_delay = 1'b0;
   logic [31:0] cause_new, sr_new, epc_new, redir_pc;
   logic        redir_valid;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #5 clk = ~clk;

   exc_entry_unit u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .fetch_pc(fetch_pc), .insn_word(insn_word), .in_delay(in_delay),
      .cause_cur(cause_cur), .sr_cur(sr_cur), .epc_cur(epc_cur),
      .cause_new(cause_new), .sr_new(sr_new), .epc_new(epc_new),
      .redir_valid(redir_valid), .redir_pc(redir_pc)
   );

   typedef struct packed {
      logic [4:0]  code;
      logic [31:0] pc;
      logic [31:0] insn;
      logic        bd;
      logic [31:0] cin;
      logic [31:0] sin;
      logic [31:0] x_cause;
      logic [31:0] x_sr;
      logic [31:0] x_epc;
      logic [31:0] x_vec;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VT [NV] = '{
      '{5'd10, 32'h0000_1004, 32'h0C00_0000, 1'b0, 32'hFFFF_FFFF, 32'h0000_000F,
        32'h3000_0328, 32'h0000_003C, 32'h0000_1000, 32'h8000_0080},
      '{5'd10, 32'h8002_0010, 32'h0400_0000, 1'b1, 32'h0000_0100, 32'h1000_0005,
        32'h9000_0128, 32'h1000_0014, 32'h8002_0008, 32'h8000_0080},
      '{5'd9,  32'hBFC0_0180, 32'h0C00_0000, 1'b0, 32'h0000_FF7C, 32'h0000_003F,
        32'h0000_0324, 32'h0000_003C, 32'hBFC0_0180, 32'h8000_0040},
      '{5'd9,  32'h0000_0008, 32'hFFFF_FFFF, 1'b1, 32'h0000_0200, 32'hFFFF_FFC2,
        32'h8000_0224, 32'hFFFF_FFC8, 32'h0000_0004, 32'h8000_0040},
      '{5'd10, 32'h0000_0004, 32'h0800_0000, 1'b1, 32'h0000_0000, 32'h0000_000A,
        32'hA000_0028, 32'h0000_0028, 32'hFFFF_FFFC, 32'h8000_0080},
      '{5'd10, 32'h0040_0000, 32'h0000_0000, 1'b0, 32'h7FFF_FCFF, 32'h0000_0030,
        32'h0000_0028, 32'h0000_0000, 32'h003F_FFFC, 32'h8000_0080}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic load(input vec_t v);
      exc_code = v.code; fetch_pc = v.pc; insn_word = v.insn; in_delay = v.bd;
      cause_cur = v.cin; sr_cur = v.sin; epc_cur = 32'h1234_5678;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      check("R10 cause", cause_new, 0);
      check("R10 sr", sr_new, 0);
      check("R10 epc", epc_new, 0);
      check("R10 pc", redir_pc, 0);
      check("R10 valid", {31'b0, redir_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", {31'b0, redir_valid}, 0);

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         load(VT[i]);
         exc_req = 1'b1;
         @(negedge clk);
         exc_req = 1'b0;
         check("R1/R2/R3/R4 cause", cause_new, VT[i].x_cause);
         check("R5 sr", sr_new, VT[i].x_sr);
         check("R6 epc", epc_new, VT[i].x_epc);
         check("R7 vector", redir_pc, VT[i].x_vec);
         check("R8 pulse high", {31'b0, redir_valid}, 1);
         @(negedge clk);
         check("R8 pulse low", {31'b0, redir_valid}, 0);
      end

      // R9: change inputs with no request, outputs hold vector 5 results
      load(VT[1]);
      repeat (3) @(negedge clk);
      check("R9 cause hold", cause_new, VT[5].x_cause);
      check("R9 sr hold", sr_new, VT[5].x_sr);
      check("R9 epc hold", epc_new, VT[5].x_epc);
      check("R9 pc hold", redir_pc, VT[5].x_vec);
      check("R9 no pulse", {31'b0, redir_valid}, 0);

      // R8: back-to-back requests, breakpoint then reserved instruction
      load(VT[3]);
      exc_req = 1'b1;
      @(negedge clk);
      check("R8 b2b first pulse", {31'b0, redir_valid}, 1);
      check("R7 b2b first vec", redir_pc, 32'h8000_0040);
      load(VT[0]);
      @(negedge clk);
      exc_req = 1'b0;
      check("R8 b2b second pulse", {31'b0, redir_valid}, 1);
      check("R3 b2b ce field", cause_new, VT[0].x_cause);
      check("R6 b2b epc", epc_new, VT[0].x_epc);
      @(negedge clk);
      check("R8 b2b end", {31'b0, redir_valid}, 0);

      // R10: reset mid-run clears results
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 re-reset cause", cause_new, 0);
      check("R10 re-reset epc", epc_new, 0);
      rst_n = 1'b1;

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule